// File: doc/BRIEF.md
# Multi-Channel Edge Timestamp Capture

This block watches four asynchronous digital inputs and turns their transitions into 64-bit timestamped event messages. Each input is first brought into the clock domain by a two-flop synchroniser. A filter then changes the clean level of the input only after the synchronised value has held a new state for a set number of consecutive cycles. Rising and falling transitions of the clean levels are detected separately. Each channel has its own enable bit for each polarity.

Surviving transitions are stamped with a 48-bit free-running cycle counter and written into an on-chip message queue. Transitions on several channels in the same cycle become one message. A downstream consumer drains the queue through a valid/ready handshake. If an event arrives while the queue is full, it is dropped. Once a slot frees up, a marker message is queued ahead of any further event. The marker tells the consumer that an unknown number of messages are missing at that point.

Top module: `esc_capture`

## Requirements
- R1: After reset the output valid `msg_valid_o` is low and stays low while no input changes.
- R2: A level on an input that lasts fewer than FILT_LEN (default 4) clock cycles produces no message. A level lasting FILT_LEN or more cycles is accepted.
- R3: An enabled rising transition on channel c produces a message with bit 63 = 0, bits 62:56 = 0, bit 52+c set as the only bit of the channel field 55:52, and level bit 48+c = 1. The level field 51:48 holds the clean levels of all channels after the transition.
- R4: An enabled falling transition on channel c produces a message with bit 52+c set and level bit 48+c = 0.
- R5: A transition whose polarity enable bit is low for its channel (`rise_en_i[c]` for rising, `fall_en_i[c]` for falling) produces no message.
- R6: Enabled transitions on several channels in the same cycle produce a single message. Its channel field has one bit set for each of those channels.
- R7: Bits 47:0 hold a cycle counter that advances by one every clock. The difference between the stamps of two messages equals the number of cycles between the two input transitions.
- R8: The queue holds FIFO_DEPTH messages (default 4096) and returns them in the order they were produced.
- R9: An event that finds the queue full is dropped. When a slot next becomes free, a marker message (bit 63 = 1, bits 62:48 = 0, bits 47:0 = stamp) is queued before any later event message.
- R10: A message leaves the queue only on a cycle with `msg_valid_o` and `msg_ready_i` both high. While `msg_valid_o` is high and `msg_ready_i` is low, `msg_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sig_i | input | 4 | Asynchronous digital inputs, one per channel |
| rise_en_i | input | 4 | Per-channel enable for rising-transition events |
| fall_en_i | input | 4 | Per-channel enable for falling-transition events |
| msg_o | output | 64 | Head message of the queue |
| msg_valid_o | output | 1 | Head message is present |
| msg_ready_i | input | 1 | Consumer accepts the head message |

## Verification
The bench builds the block with FIFO_DEPTH set to 8 and FILT_LEN left at 4. With a depth of 8, a dozen transitions fill the queue, force drops and bring the marker insertion within reach in a few hundred cycles. The default filter length lets the bench probe the exact 3-cycle rejection and 4-cycle acceptance boundary. Timestamp checks use differences between messages, so they do not depend on how many cycles reset took.

// File: rtl/esc_pkg.sv
package esc_pkg;
  localparam int unsigned N_CH  = 4;
  localparam int unsigned TS_W  = 48;
  localparam int unsigned MSG_W = 64;

  typedef logic [MSG_W-1:0] msg_t;

  function automatic msg_t build_msg(input logic marker, input logic [N_CH-1:0] chan,
                                     input logic [N_CH-1:0] lvl, input logic [TS_W-1:0] ts);
    msg_t m;
    m = '0;
    m[63]       = marker;
    m[55:52]    = chan;
    m[51:48]    = lvl;
    m[TS_W-1:0] = ts;
    return m;
  endfunction
endpackage

// File: rtl/esc_in_filter.sv
module esc_in_filter #(
  parameter int unsigned FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic lvl_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic          s1_q, s2_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= raw_i;
      s2_q <= s1_q;
    end
  end

  // level flips on the FILT_LEN-th consecutive differing sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_o <= 1'b0;
    end else if (s2_q == lvl_o) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_LEN - 1)) begin
      cnt_q <= '0;
      lvl_o <= s2_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/esc_event_gen.sv
module esc_event_gen
  import esc_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] lvl_i,
  input  logic [N_CH-1:0] rise_en_i,
  input  logic [N_CH-1:0] fall_en_i,
  input  logic            full_i,
  output logic            wr_o,
  output msg_t            wr_data_o
);
  logic [N_CH-1:0] lvl_q;
  logic [TS_W-1:0] ts_q;
  logic            lost_q;
  logic [N_CH-1:0] hit;
  logic            ev;

  assign hit = (lvl_i & ~lvl_q & rise_en_i) | (~lvl_i & lvl_q & fall_en_i);
  assign ev  = |hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= '0;
      ts_q  <= '0;
    end else begin
      lvl_q <= lvl_i;
      ts_q  <= ts_q + 1'b1;
    end
  end

  always_comb begin
    wr_o      = 1'b0;
    wr_data_o = build_msg(1'b0, hit, lvl_i, ts_q);
    if (!full_i) begin
      if (lost_q) begin
        wr_o      = 1'b1;
        wr_data_o = build_msg(1'b1, '0, '0, ts_q);
      end else if (ev) begin
        wr_o = 1'b1;
      end
    end
  end

  // an event coinciding with the marker write is itself lost: keep flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lost_q <= 1'b0;
    else if (full_i && ev)      lost_q <= 1'b1;
    else if (!full_i && lost_q) lost_q <= ev;
  end
endmodule

// File: rtl/esc_msg_fifo.sv
module esc_msg_fifo #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned W     = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic         full_o,
  input  logic         rd_i,
  output logic [W-1:0] rd_data_o,
  output logic         valid_o
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp_q, rp_q;

  assign full_o    = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign valid_o   = (wp_q != rp_q);
  assign rd_data_o = mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_i && !full_o) mem[wp_q[AW-1:0]] <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_i && !full_o) wp_q <= wp_q + 1'b1;
      if (rd_i && valid_o) rp_q <= rp_q + 1'b1;
    end
  end
endmodule

// File: rtl/esc_capture.sv
module esc_capture
  import esc_pkg::*;
#(
  parameter int unsigned FILT_LEN   = 4,
  parameter int unsigned FIFO_DEPTH = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  sig_i,
  input  logic [3:0]  rise_en_i,
  input  logic [3:0]  fall_en_i,
  output logic [63:0] msg_o,
  output logic        msg_valid_o,
  input  logic        msg_ready_i
);
  logic [N_CH-1:0] lvl;
  logic            full, wr;
  msg_t            wr_data;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    esc_in_filter #(.FILT_LEN(FILT_LEN)) i_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .raw_i (sig_i[c]),
      .lvl_o (lvl[c])
    );
  end

  esc_event_gen i_evt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (lvl),
    .rise_en_i(rise_en_i),
    .fall_en_i(fall_en_i),
    .full_i   (full),
    .wr_o     (wr),
    .wr_data_o(wr_data)
  );

  esc_msg_fifo #(.DEPTH(FIFO_DEPTH), .W(MSG_W)) i_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr),
    .wr_data_i(wr_data),
    .full_o   (full),
    .rd_i     (msg_ready_i),
    .rd_data_o(msg_o),
    .valid_o  (msg_valid_o)
  );
endmodule

// File: rtl/esc_capture_chk.sv
module esc_capture_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [63:0] msg_o,
  input logic        msg_valid_o,
  input logic        msg_ready_i
);
  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_o));

  p_rsv_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_o[62:56] == 7'd0);

  p_marker_fmt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_o[63] |-> msg_o[55:48] == 8'd0);

  p_chan_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_o[63] |-> msg_o[55:52] != 4'd0);
endmodule

bind esc_capture esc_capture_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .msg_o      (msg_o),
  .msg_valid_o(msg_valid_o),
  .msg_ready_i(msg_ready_i)
);

// File: tb/test_esc_capture.sv
module test_esc_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  sig = '0, ren = '0, fen = '0;
  logic [63:0] msg;
  logic        vld;
  logic        rdy = 1'b0;
  int          n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  esc_capture #(.FILT_LEN(4), .FIFO_DEPTH(8)) i_esc_capture (
    .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .rise_en_i(ren), .fall_en_i(fen),
    .msg_o(msg), .msg_valid_o(vld), .msg_ready_i(rdy)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // pop head: returns 1 and message if valid within a short window
  task automatic pop(output bit got, output logic [63:0] m);
    got = 1'b0;
    m   = '0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (vld) begin
        got = 1'b1;
        m   = msg;
        rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
        break;
      end
    end
  endtask

  task automatic pulse(input int ch, input int len);
    @(negedge clk);
    sig[ch] = 1'b1;
    idle(len);
    sig[ch] = 1'b0;
  endtask

  task automatic t_reset;
    idle(5);
    check(vld == 1'b0, "R1 valid after reset", 64'(vld), 64'd0);
  endtask

  task automatic t_rise_fall;
    bit g1, g2; logic [63:0] a, b;
    ren = 4'b0010; fen = 4'b0010;
    pulse(1, 6);
    idle(12);
    pop(g1, a); pop(g2, b);
    check(g1 && a[63:48] == 16'h0022, "R3 rise message", a, 64'h0022_0000_0000_0000);
    check(g2 && b[63:48] == 16'h0020, "R4 fall message", b, 64'h0020_0000_0000_0000);
    check(b[47:0] - a[47:0] == 48'd6, "R7 stamp delta", 64'(b[47:0] - a[47:0]), 64'd6);
  endtask

  task automatic t_glitch;
    bit g1, g2; logic [63:0] a, b;
    ren = 4'b0001; fen = 4'b0001;
    pulse(0, 3);
    idle(15);
    check(vld == 1'b0, "R2 3-cycle pulse rejected", 64'(vld), 64'd0);
    pulse(0, 4);
    idle(12);
    pop(g1, a); pop(g2, b);
    check(g1 && g2 && a[48] && !b[48], "R2 4-cycle pulse accepted", {a[51:48], b[51:48]}, 64'h10);
    check(b[47:0] - a[47:0] == 48'd4, "R7 stamp delta 4", 64'(b[47:0] - a[47:0]), 64'd4);
  endtask

  task automatic t_enable;
    bit g1; logic [63:0] a;
    ren = 4'b0000; fen = 4'b0100;
    pulse(2, 8);
    idle(12);
    pop(g1, a);
    check(g1 && a[55:48] == 8'h40, "R5 only falling enabled", a, 64'h0040_0000_0000_0000);
    check(vld == 1'b0, "R5 rising suppressed", 64'(vld), 64'd0);
  endtask

  task automatic t_merge;
    bit g1, g2; logic [63:0] a, b;
    ren = 4'b1001; fen = 4'b1001;
    @(negedge clk); sig = 4'b1001;
    idle(10); sig = 4'b0000;
    idle(12);
    pop(g1, a); pop(g2, b);
    check(g1 && a[55:48] == 8'h99, "R6 merged rise", a, 64'h0099_0000_0000_0000);
    check(g2 && b[55:48] == 8'h90, "R6 merged fall", b, 64'h0090_0000_0000_0000);
    check(vld == 1'b0, "R6 single message per cycle", 64'(vld), 64'd0);
  endtask

  task automatic t_hold;
    logic [63:0] h; bit ok; bit g1, g2; logic [63:0] a, b;
    ren = 4'b0010; fen = 4'b0010;
    pulse(1, 6);
    idle(12);
    h = msg; ok = vld;
    idle(6);
    check(ok && vld && msg == h, "R10 held while not ready", msg, h);
    pop(g1, a); pop(g2, b);
    check(g1 && g2 && a == h && b[51:48] == 4'h0, "R10 pop order", b, 64'h0);
  endtask

  task automatic t_overflow;
    bit g; logic [63:0] m, prev;
    ren = 4'b0001; fen = 4'b0001;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); sig[0] = ~sig[0];
      idle(5);
    end
    idle(12);
    for (int i = 0; i < 8; i++) begin
      pop(g, m);
      check(g && !m[63] && m[48] == ((i % 2) == 0), "R8 order and depth", m[51:48], 64'((i % 2) == 0));
      if (i > 0) check(m[47:0] - prev[47:0] == 48'd6, "R7 toggle spacing", 64'(m[47:0] - prev[47:0]), 64'd6);
      prev = m;
    end
    pop(g, m);
    check(g && m[63] && m[62:48] == 15'd0, "R9 marker after drops", m, 64'h8000_0000_0000_0000);
    check(vld == 1'b0, "R9 dropped events absent", 64'(vld), 64'd0);
    pulse(0, 6);
    idle(12);
    pop(g, m);
    check(g && !m[63] && m[55:48] == 8'h11, "R9 event after marker", m, 64'h0011_0000_0000_0000);
    pop(g, m);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_rise_fall();
    t_glitch();
    t_enable();
    t_merge();
    t_hold();
    t_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule